// File: doc/BRIEF.md
# Accelerometer SPI Target with Conversion Readback

This block is the four-wire serial target of a three-axis acceleration sensor. A host lowers chip select and sends a command byte MSB first. A set top bit selects a read and a clear top bit selects a write. A write takes sixteen serial clocks: the address byte, then a data byte that lands in one of two control registers. A write of the reload key to the key address asks the sensor to reload its calibration. A read returns register bytes on SDO from the second byte on. When the read address names one of the four conversion outputs (X, Y, Z, auxiliary), the command byte also starts a 12-bit conversion of that channel. The host then holds SCLK low while the converter works and clocks the result out, left-justified in two bytes.

If the host keeps clocking, the target walks a fixed order of bytes. The order is the eight output bytes, then control register C, control register B, then the status byte. It returns zeros after that. Raising chip select restarts the walk. All pins are sampled into the block's own clock through synchronizers. The converter sits outside the block. It takes a one-cycle start pulse with a channel number and returns a one-cycle done pulse with the result, which the block stores per channel.

States: `S_IDLE` (chip select high) goes to `S_CMD` when chip select falls. `S_CMD` shifts in eight bits. On the eighth rising edge it goes to `S_TURN` for a read or to `S_WDATA` for a write. `S_TURN` goes to `S_RDATA` on the next falling edge, which enables SDO. `S_WDATA` commits on the sixteenth rising edge and goes to `S_WDONE`, where it ignores any further bits. A high chip select sends every state back to `S_IDLE`.

Top module: `accel_spi_target`

## Requirements
- R1: After reset, ctrl_c is 0xE1, ctrl_b is 0x40, and sdo_oe, conv_start and cal_reload are low.
- R2: A write command (top bit 0) to address 0x0C loads the following data byte into ctrl_c, and a write to 0x0D loads it into ctrl_b. The load happens on the sixteenth SCLK rising edge.
- R3: Writing data 0xCA to address 0x0A gives exactly one one-cycle cal_reload pulse. Any other data written to 0x0A gives none.
- R4: Read addresses 0x8C, 0x8D and 0x8E return ctrl_c, ctrl_b and status_in in the second byte, MSB first. SDI is sampled on SCLK rising edges and SDO changes after SCLK falling edges.
- R5: sdo_oe is low while chip select is high, during the command byte, and for the whole of a write.
- R6: A read of 0x80..0x87 gives one conv_start pulse on the eighth rising edge, with conv_axis equal to address bits 2:1 (X=0, Y=1, Z=2, aux=3). Other reads give none.
- R7: The even output byte of a channel holds result bits 11..4. The odd byte holds bits 3..0 followed by four zero bits.
- R8: Each returned byte takes the stored value at that byte's first SCLK rising edge. Clocking out before the converter's done pulse returns the previously stored result.
- R9: Auto-increment continues from the addressed byte through the remaining output bytes, then ctrl_c, ctrl_b and status_in.
- R10: Bytes after status_in, and every byte of a read from an address outside the map, are 0x00.
- R11: Raising chip select restarts the byte walk. A write cut short before the sixteenth edge changes no register.
- R12: Writes to any address other than 0x0A, 0x0C and 0x0D leave ctrl_c and ctrl_b unchanged and give no cal_reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Drive enable for SDO; low means high impedance |
| status_in | input | 8 | Status byte from the register file |
| ctrl_c | output | 8 | Control register C |
| ctrl_b | output | 8 | Control register B |
| cal_reload | output | 1 | One-cycle calibration reload request |
| conv_start | output | 1 | One-cycle conversion start |
| conv_axis | output | 2 | Channel of the requested conversion |
| conv_done | input | 1 | One-cycle conversion complete |
| conv_result | input | 12 | Conversion result, valid with conv_done |

## Verification
The hardest case to reach is a host that clocks the result out before the converter finishes. The block must then return the old stored value, and a later walk must show the new value. The bench models the converter with a fixed delay of several hundred cycles. It runs one Z read with a gap longer than that delay, then a Z read with a short gap, then an X read whose walk reaches the Z bytes after the second conversion has landed. The cut-short write needs chip select raised in mid-byte, and the bench sends only twelve bits for it.

// File: rtl/ast_pkg.sv
package ast_pkg;
    localparam int RES_W     = 12;
    localparam int N_CH      = 4;
    localparam int CH_W      = $clog2(N_CH);
    localparam int OUT_BYTES = 2 * N_CH;
    localparam int POS_W     = 4;

    localparam logic [POS_W-1:0] POS_C   = POS_W'(OUT_BYTES);
    localparam logic [POS_W-1:0] POS_B   = POS_C + POS_W'(1);
    localparam logic [POS_W-1:0] POS_S   = POS_C + POS_W'(2);
    localparam logic [POS_W-1:0] POS_END = POS_C + POS_W'(3);

    localparam logic [7:0] WADDR_KEY  = 8'h0A;
    localparam logic [7:0] WADDR_C    = 8'h0C;
    localparam logic [7:0] WADDR_B    = 8'h0D;
    localparam logic [7:0] RELOAD_KEY = 8'hCA;
    localparam logic [7:0] C_RST      = 8'hE1;
    localparam logic [7:0] B_RST      = 8'h40;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD, S_TURN, S_RDATA, S_WDATA, S_WDONE
    } state_t;

    // Maps a read command onto its place in the fixed byte walk.
    function automatic logic [POS_W-1:0] start_pos(input logic [7:0] cmd);
        logic [POS_W-1:0] p;
        if (cmd[6:3] == 4'd0)        p = {1'b0, cmd[2:0]};
        else if (cmd[6:0] == 7'h0C)  p = POS_C;
        else if (cmd[6:0] == 7'h0D)  p = POS_B;
        else if (cmd[6:0] == 7'h0E)  p = POS_S;
        else                         p = POS_END;
        return p;
    endfunction
endpackage

// File: rtl/ast_sync.sv
module ast_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/ast_results.sv
module ast_results
    import ast_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [CH_W-1:0]       axis,
    input  logic [RES_W-1:0]      din,
    output logic [N_CH*RES_W-1:0] res_flat
);
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [RES_W-1:0] r;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          r <= '0;
            else if (load && axis == CH_W'(c))   r <= din;
        end
        assign res_flat[c*RES_W +: RES_W] = r;
    end
endmodule

// File: rtl/ast_bytesel.sv
module ast_bytesel
    import ast_pkg::*;
(
    input  logic [POS_W-1:0]      pos,
    input  logic [N_CH*RES_W-1:0] res_flat,
    input  logic [7:0]            ctrl_c,
    input  logic [7:0]            ctrl_b,
    input  logic [7:0]            status_in,
    output logic [7:0]            byte_out
);
    localparam int LO_W  = RES_W - 8;
    localparam int PAD_W = 16 - RES_W;

    logic [CH_W-1:0]  ch;
    logic [RES_W-1:0] r;

    assign ch = pos[CH_W:1];
    assign r  = res_flat[ch*RES_W +: RES_W];

    always_comb begin
        if (pos < POS_C)       byte_out = pos[0] ? {r[LO_W-1:0], {PAD_W{1'b0}}}
                                                 : r[RES_W-1 -: 8];
        else if (pos == POS_C) byte_out = ctrl_c;
        else if (pos == POS_B) byte_out = ctrl_b;
        else if (pos == POS_S) byte_out = status_in;
        else                   byte_out = 8'h00;
    end
endmodule

// File: rtl/accel_spi_target.sv
module accel_spi_target
    import ast_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        sdi,
    output logic        sdo,
    output logic        sdo_oe,
    input  logic [7:0]  status_in,
    output logic [7:0]  ctrl_c,
    output logic [7:0]  ctrl_b,
    output logic        cal_reload,
    output logic        conv_start,
    output logic [1:0]  conv_axis,
    input  logic        conv_done,
    input  logic [11:0] conv_result
);
    logic [2:0] pins_q;
    logic cs_q, sclk_q, sdi_q, sclk_d, rise, fall;

    ast_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, sdi}), .q(pins_q)
    );
    assign cs_q   = pins_q[2];
    assign sclk_q = pins_q[1];
    assign sdi_q  = pins_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_q;
    end
    assign rise = sclk_q & ~sclk_d;
    assign fall = ~sclk_q & sclk_d;

    state_t           state, state_nx;
    logic [4:0]       cnt;
    logic [7:0]       shin, waddr, sh, live;
    logic [7:0]       cmd_now;
    logic [POS_W-1:0] pos;
    logic [2:0]       bitn;
    logic             hi;
    logic [N_CH*RES_W-1:0] res_flat;

    assign cmd_now = {shin[6:0], sdi_q};

    ast_results u_res (
        .clk(clk), .rst_n(rst_n), .load(conv_done), .axis(conv_axis),
        .din(conv_result), .res_flat(res_flat)
    );

    ast_bytesel u_sel (
        .pos(pos), .res_flat(res_flat), .ctrl_c(ctrl_c), .ctrl_b(ctrl_b),
        .status_in(status_in), .byte_out(live)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (cs_q) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  state_nx = S_CMD;
                S_CMD:   if (rise && cnt == 5'd7) state_nx = cmd_now[7] ? S_TURN : S_WDATA;
                S_TURN:  if (fall) state_nx = S_RDATA;
                S_RDATA: state_nx = S_RDATA;
                S_WDATA: if (rise && cnt == 5'd15) state_nx = S_WDONE;
                S_WDONE: state_nx = S_WDONE;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // Shift, walk and register datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; shin <= '0; waddr <= '0; sh <= '0; pos <= POS_END;
            bitn <= '0; hi <= 1'b0;
            ctrl_c <= C_RST; ctrl_b <= B_RST;
            cal_reload <= 1'b0; conv_start <= 1'b0; conv_axis <= '0;
        end else begin
            cal_reload <= 1'b0;
            conv_start <= 1'b0;
            if (state == S_IDLE) begin
                cnt <= '0; bitn <= '0; hi <= 1'b0;
            end
            if ((state == S_CMD || state == S_WDATA) && rise && !cs_q) begin
                shin <= cmd_now;
                cnt  <= cnt + 5'd1;
                if (state == S_CMD && cnt == 5'd7) begin
                    waddr <= cmd_now;
                    pos   <= start_pos(cmd_now);
                    if (cmd_now[7] && cmd_now[6:3] == 4'd0) begin
                        conv_start <= 1'b1;
                        conv_axis  <= cmd_now[2:1];
                    end
                end
                if (state == S_WDATA && cnt == 5'd15) begin
                    if (waddr == WADDR_C)        ctrl_c <= cmd_now;
                    else if (waddr == WADDR_B)   ctrl_b <= cmd_now;
                    else if (waddr == WADDR_KEY) cal_reload <= (cmd_now == RELOAD_KEY);
                end
            end
            if (state == S_RDATA && !cs_q) begin
                if (rise) begin
                    hi <= 1'b1;
                    if (bitn == 3'd0) sh <= live;
                end else if (fall) begin
                    hi   <= 1'b0;
                    sh   <= {sh[6:0], 1'b0};
                    bitn <= bitn + 3'd1;
                    if (bitn == 3'd7 && pos != POS_END) pos <= pos + POS_W'(1);
                end
            end
        end
    end

    // Outputs
    always_comb begin
        sdo_oe = (state == S_RDATA);
        if (!sdo_oe)                    sdo = 1'b0;
        else if (bitn == 3'd0 && !hi)   sdo = live[7];
        else                            sdo = sh[7];
    end

    assert_oe_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q |=> !sdo_oe);
    assert_start_turn_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> state == S_TURN);
    assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_reload_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cal_reload |=> !cal_reload);
    assert_ctrl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_WDATA) |=> ($stable(ctrl_c) && $stable(ctrl_b)));
    assert_pos_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= POS_END);
endmodule

// File: tb/sim_accel_spi_target.sv
module sim_accel_spi_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int CONV_DLY   = 300;
    localparam int LONG_GAP   = 500;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic sdo, sdo_oe, cal_reload, conv_start, conv_done;
    logic [7:0] status_in = 8'h5A, ctrl_c, ctrl_b;
    logic [1:0] conv_axis;
    logic [11:0] conv_result;

    always #(CLK_PERIOD/2) clk = ~clk;

    accel_spi_target u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .status_in(status_in), .ctrl_c(ctrl_c),
        .ctrl_b(ctrl_b), .cal_reload(cal_reload), .conv_start(conv_start),
        .conv_axis(conv_axis), .conv_done(conv_done), .conv_result(conv_result)
    );

    int n_checks = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [7:0] txb[16], rxb[16];
    logic [11:0] exp_res[4];
    logic [7:0] exp_c = 8'hE1, exp_b = 8'h40;
    int starts_seen = 0, reloads_seen = 0, last_axis = -1;
    bit in_cmd = 1'b0;
    int cs_hi_cnt = 0, cs_lo_cnt = 0;

    // Converter model: fixed delay, per-axis values from a running seed
    int conv_cnt = 0, conv_ax = 0;
    logic [11:0] seed = 12'h9C5;
    initial begin
        for (int i = 0; i < 4; i++) exp_res[i] = 12'h000;
    end
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_cnt > 0) begin
            conv_cnt <= conv_cnt - 1;
            if (conv_cnt == 1) begin
                conv_done   <= 1'b1;
                conv_result <= seed;
                exp_res[conv_ax] <= seed;
                seed <= seed + 12'h3A7;
            end
        end
        if (rst_n && conv_start) begin
            starts_seen <= starts_seen + 1;
            last_axis   <= int'(conv_axis);
            conv_ax     <= int'(conv_axis);
            conv_cnt    <= CONV_DLY;
        end
        if (rst_n && cal_reload) reloads_seen <= reloads_seen + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of the drive enable against the host-side phase
    always @(negedge clk) begin
        if (cs_n) begin cs_hi_cnt++; cs_lo_cnt = 0; end
        else      begin cs_lo_cnt++; cs_hi_cnt = 0; end
        if (rst_n && (cs_hi_cnt >= 4 || (in_cmd && cs_lo_cnt >= 4))) begin
            n_checks++;
            if (sdo_oe) begin
                n_fail++;
                $display("FAIL R5 sdo_oe actual=1 expected=0 at %0t", $time);
            end
        end
    end

    function automatic logic [7:0] exp_byte(input int p);
        logic [11:0] r;
        if (p < 8) begin
            r = exp_res[p/2];
            return (p % 2 == 1) ? {r[3:0], 4'h0} : r[11:4];
        end
        if (p == 8)  return exp_c;
        if (p == 9)  return exp_b;
        if (p == 10) return status_in;
        return 8'h00;
    endfunction

    function automatic int start_of(input logic [7:0] a);
        if (a >= 8'h80 && a <= 8'h87) return int'(a) - 8'h80;
        if (a == 8'h8C) return 8;
        if (a == 8'h8D) return 9;
        if (a == 8'h8E) return 10;
        return 11;
    endfunction

    task automatic spi_run(input int nb, input int gap, input int nbits);
        int total;
        total = (nbits > 0) ? nbits : nb * 8;
        cs_n = 1'b0; in_cmd = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < total; i++) begin
            sdi = txb[i/8][7-(i%8)];
            repeat (HALF) @(negedge clk);
            if (i >= 8) begin
                rxb[i/8][7-(i%8)] = sdo;
                if (txb[0][7]) chk("R5 oe in read data", int'(sdo_oe), 1);
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
            if (i == 7) begin
                in_cmd = 1'b0;
                repeat (gap) @(negedge clk);
            end
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input int nbits);
        txb[0] = a; txb[1] = d;
        spi_run(2, 0, nbits);
    endtask

    // Read nb bytes after the command and compare the walk from its start
    task automatic rd_check(input logic [7:0] a, input int nb, input int gap, input string tag);
        int s;
        for (int k = 0; k < 16; k++) txb[k] = 8'h00;
        txb[0] = a;
        spi_run(nb + 1, gap, 0);
        s = start_of(a);
        for (int k = 0; k < nb; k++)
            chk($sformatf("%s byte%0d pos%0d%s", tag, k, s + k,
                          (s + k >= 11) ? " R10" : (k >= 1 ? " R9" : "")),
                int'(rxb[k+1]), int'(exp_byte(s + k)));
    endtask

    initial begin
        int st0, rl0;
        logic [11:0] oldz;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 ctrl_c reset", int'(ctrl_c), 8'hE1);
        chk("R1 ctrl_b reset", int'(ctrl_b), 8'h40);
        chk("R1 sdo_oe reset", int'(sdo_oe), 0);
        chk("R1 conv_start reset", int'(conv_start), 0);
        chk("R1 cal_reload reset", int'(cal_reload), 0);

        // R4 control and status reads
        rd_check(8'h8C, 1, 0, "R4 read C");
        rd_check(8'h8D, 1, 0, "R4 read B");
        rd_check(8'h8E, 1, 0, "R4 read status");

        // R2 writes
        wr(8'h0C, 8'h23, 0); exp_c = 8'h23;
        chk("R2 ctrl_c write", int'(ctrl_c), 8'h23);
        wr(8'h0D, 8'h9F, 0); exp_b = 8'h9F;
        chk("R2 ctrl_b write", int'(ctrl_b), 8'h9F);
        rd_check(8'h8C, 3, 0, "R2 R9 readback");

        // R3 reload key
        rl0 = reloads_seen;
        wr(8'h0A, 8'hCA, 0);
        chk("R3 key gives one reload", reloads_seen - rl0, 1);
        wr(8'h0A, 8'h55, 0);
        chk("R3 wrong key no reload", reloads_seen - rl0, 1);

        // R12 writes elsewhere ignored
        wr(8'h0E, 8'h77, 0);
        wr(8'h0B, 8'h11, 0);
        wr(8'h20, 8'hCA, 0);
        chk("R12 ctrl_c unchanged", int'(ctrl_c), int'(exp_c));
        chk("R12 ctrl_b unchanged", int'(ctrl_b), int'(exp_b));
        chk("R12 no reload", reloads_seen - rl0, 1);

        // R11 cut-short write
        wr(8'h0C, 8'h11, 12);
        chk("R11 aborted write", int'(ctrl_c), int'(exp_c));

        // R6 R7 R9 R10 full walk from X after a finished conversion
        st0 = starts_seen;
        rd_check(8'h80, 13, LONG_GAP, "R7 walk from X");
        chk("R6 one start for X", starts_seen - st0, 1);
        chk("R6 axis X", last_axis, 0);

        // R8 Z: long gap, then short gap returns previous value
        rd_check(8'h84, 2, LONG_GAP, "R7 Z long");
        chk("R6 axis Z", last_axis, 2);
        oldz = exp_res[2];
        for (int k = 0; k < 16; k++) txb[k] = 8'h00;
        txb[0] = 8'h84;
        spi_run(3, 20, 0);
        chk("R8 early Z high", int'(rxb[1]), int'(oldz[11:4]));
        chk("R8 early Z low", int'(rxb[2]), int'({oldz[3:0], 4'h0}));
        repeat (CONV_DLY + 20) @(negedge clk);
        chk("R8 Z updated later", int'(exp_res[2] != oldz), 1);
        rd_check(8'h80, 6, LONG_GAP, "R8 walk sees new Z");

        // aux channel and mid-walk start
        rd_check(8'h86, 2, LONG_GAP, "R7 aux");
        chk("R6 axis aux", last_axis, 3);
        rd_check(8'h87, 6, LONG_GAP, "R9 walk from aux low");

        // R10 unmapped read and no conversion on control reads
        st0 = starts_seen;
        rd_check(8'h90, 3, 0, "R10 unmapped");
        rd_check(8'h8D, 4, 0, "R10 walk past status");
        chk("R6 no start on non-output reads", starts_seen - st0, 0);

        // R11 restart after chip select
        rd_check(8'h8E, 2, 0, "R11 restart");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule